// File: doc/BRIEF.md
# Transmit Low-Power-Idle Controller

This block decides when an Ethernet transmitter stops sending normal idle and starts requesting the low-power-idle (LPI) pattern, and when it returns to normal transmission. It holds one 32-bit control and status word that is read and written through a simple register port. It watches a frame-pending level, a new-frame strobe, a FIFO flush strobe and a PHY link input. It drives an LPI-pattern request and a transmit-ready signal.

The block has two operating modes. In manual mode, the software enable bit alone commands entry and exit. In automatic mode, entry is held off until the transmit path has drained. Exit then follows a newly offered frame or a flush, and the hardware clears the enable bit on that exit. In both modes, entry is allowed only after the qualified link has stayed up for a programmable number of cycles. Every exit passes through a wake period of programmable length, and transmit-ready stays low until that period ends.

Top module: `eee_txlpi_ctrl`

## Requirements
- R1: The register sits at offset 0x30. Its control bits are read/write and reset to 0. Bit 16 is the enable, bit 17 is the software link-up flag, bit 18 selects use of the PHY link input, and bit 19 selects automatic mode. Every other bit written is discarded. A write to any other offset leaves the register unchanged. A read at any other offset returns 0.
- R2: The qualified link is the software link flag alone when bit 18 is 0. It is the AND of that flag and `phy_link_up` when bit 18 is 1. Entry requires the qualified link to have been high at `ls_cycles` consecutive clock edges, and the count restarts whenever the qualified link is low.
- R3: In manual mode (bit 19 = 0), `lpi_req` rises on the clock edge after the enable is 1 and the link qualification is met.
- R4: Clearing the enable while in LPI drops `lpi_req` on the next clock edge.
- R5: On every exit, `tx_ready` goes low together with the fall of `lpi_req`. It stays low for max(`tw_cycles`,1) cycles and then returns high.
- R6: In automatic mode, entry is held off while `frame_pending` or `new_frame` is high.
- R7: In automatic mode, a `new_frame` or `fifo_flush` strobe during LPI exits LPI on the next edge and clears the enable bit.
- R8: In manual mode, a `fifo_flush` strobe during LPI forces an exit, and the enable bit is kept.
- R9: Status bit 0 sets when LPI is entered, and status bit 1 sets when a wake period completes. A read at offset 0x30 clears both bits. A set in the same cycle as a clearing read wins.
- R10: Status bit 8 reads 1 exactly while `lpi_req` is high.
- R11: After reset, `lpi_req` is 0, `tx_ready` is 1, and the register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status flags) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed offset |
| frame_pending | input | 1 | Frames still held in the core or queued |
| new_frame | input | 1 | Strobe: a new frame is offered for transmission |
| fifo_flush | input | 1 | Strobe: transmit FIFO flush command |
| phy_link_up | input | 1 | Link status reported by the PHY |
| ls_cycles | input | 16 | Link-up qualification length in cycles |
| tw_cycles | input | 16 | Wake period length in cycles |
| lpi_req | output | 1 | Request to send the LPI pattern |
| tx_ready | output | 1 | Normal transmission may proceed |

## Verification
A corrupted state register shows up either as `lpi_req` and `tx_ready` disagreeing with the mode, or as status bit 8 disagreeing with `lpi_req`. Either mismatch is visible one cycle after the faulty edge. A link-qualification counter that is off by one moves the entry edge by exactly one cycle, so the bench samples the cycle just before and the cycle just after the expected rise. A wrong wake counter stretches or shortens the low time of `tx_ready`, which the bench times directly. Flag priority errors appear on the next register read.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

    localparam int unsigned REG_W      = 32;
    localparam logic [7:0]  CSR_OFFSET = 8'h30;
    localparam int unsigned CTRL_LSB   = 16;
    localparam int unsigned STS_ENTER  = 0;
    localparam int unsigned STS_EXIT   = 1;
    localparam int unsigned STS_ACTIVE = 8;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LPI    = 2'd1,
        ST_WAKE   = 2'd2
    } lpi_state_e;

    // packed MSB first: bit 19 .. bit 16
    typedef struct packed {
        logic auto_mode;
        logic use_phy;
        logic link_sw;
        logic lpi_en;
    } lpi_ctrl_t;

    typedef struct packed {
        logic entered;
        logic exited;
    } lpi_flags_t;

    function automatic logic [REG_W-1:0] pack_csr(lpi_ctrl_t c, lpi_flags_t f, logic active);
        logic [REG_W-1:0] v;
        v = '0;
        v[CTRL_LSB +: 4] = c;
        v[STS_ENTER]     = f.entered;
        v[STS_EXIT]      = f.exited;
        v[STS_ACTIVE]    = active;
        return v;
    endfunction

endpackage

// File: rtl/lpi_csr.sv
module lpi_csr
    import eee_lpi_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              hw_clr_en,
    input  logic              ev_enter,
    input  logic              ev_exit,
    input  logic              lpi_active,
    output lpi_ctrl_t         ctrl,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(CSR_OFFSET);

    lpi_flags_t flags;
    logic       hit;

    assign hit = (reg_addr == OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            flags <= '0;
        end else begin
            if (reg_wr && hit)
                ctrl <= lpi_ctrl_t'(reg_wdata[CTRL_LSB +: 4]);
            if (hw_clr_en)
                ctrl.lpi_en <= 1'b0;
            if (reg_rd && hit)
                flags <= '0;
            if (ev_enter)
                flags.entered <= 1'b1;
            if (ev_exit)
                flags.exited <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit)
            reg_rdata = pack_csr(ctrl, flags, lpi_active);
    end

    // R9
    enter_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev_enter |=> flags.entered);

    // R9
    flag_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && hit && !ev_enter) |=> !flags.entered);

    // R7
    hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hw_clr_en |=> !ctrl.lpi_en);

endmodule

// File: rtl/lpi_link_qual.sv
module lpi_link_qual
    import eee_lpi_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  lpi_ctrl_t        ctrl,
    input  logic             phy_link_up,
    input  logic [CNT_W-1:0] ls_cycles,
    output logic             link_qual
);

    logic             link_ok;
    logic [CNT_W-1:0] up_cnt;

    assign link_ok = ctrl.link_sw & (ctrl.use_phy ? phy_link_up : 1'b1);

    always_ff @(posedge clk) begin
        if (rst)
            up_cnt <= '0;
        else if (!link_ok)
            up_cnt <= '0;
        else if (up_cnt < ls_cycles)
            up_cnt <= up_cnt + 1'b1;
    end

    assign link_qual = link_ok && (up_cnt >= ls_cycles);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!link_ok && ls_cycles != '0) |=> !link_qual || ls_cycles == '0);

endmodule

// File: rtl/lpi_tx_fsm.sv
module lpi_tx_fsm
    import eee_lpi_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  lpi_ctrl_t        ctrl,
    input  logic             link_qual,
    input  logic             frame_pending,
    input  logic             new_frame,
    input  logic             fifo_flush,
    input  logic [CNT_W-1:0] tw_cycles,
    output logic             lpi_req,
    output logic             tx_ready,
    output logic             ev_enter,
    output logic             ev_exit,
    output logic             hw_clr_en
);

    lpi_state_e       state, state_nx;
    logic [CNT_W-1:0] tw_cnt;
    logic             tw_done;
    logic             drained;

    assign drained = !ctrl.auto_mode || (!frame_pending && !new_frame);
    assign tw_done = ({1'b0, tw_cnt} + 1'b1) >= {1'b0, tw_cycles};

    always_comb begin
        state_nx  = state;
        ev_enter  = 1'b0;
        ev_exit   = 1'b0;
        hw_clr_en = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                if (ctrl.lpi_en && link_qual && drained) begin
                    state_nx = ST_LPI;
                    ev_enter = 1'b1;
                end
            end
            ST_LPI: begin
                if (!ctrl.lpi_en || fifo_flush || (ctrl.auto_mode && new_frame)) begin
                    state_nx  = ST_WAKE;
                    hw_clr_en = ctrl.auto_mode && (fifo_flush || new_frame);
                end
            end
            ST_WAKE: begin
                if (tw_done) begin
                    state_nx = ST_ACTIVE;
                    ev_exit  = 1'b1;
                end
            end
            default: state_nx = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_ACTIVE;
            tw_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAKE && !tw_done)
                tw_cnt <= tw_cnt + 1'b1;
            else
                tw_cnt <= '0;
        end
    end

    assign lpi_req  = (state == ST_LPI);
    assign tx_ready = (state == ST_ACTIVE);

    // R3
    entry_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lpi_req) |-> $past(link_qual) && $past(ctrl.lpi_en));

    // R6
    auto_drain_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(lpi_req) && $past(ctrl.auto_mode)) |-> !$past(frame_pending));

    // R5
    wake_ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lpi_req) |-> !tx_ready);

    // R7
    auto_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (lpi_req && ctrl.auto_mode && new_frame) |=> !lpi_req);

endmodule

// File: rtl/eee_txlpi_ctrl.sv
module eee_txlpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_pending,
    input  logic              new_frame,
    input  logic              fifo_flush,
    input  logic              phy_link_up,
    input  logic [CNT_W-1:0]  ls_cycles,
    input  logic [CNT_W-1:0]  tw_cycles,
    output logic              lpi_req,
    output logic              tx_ready
);

    lpi_ctrl_t ctrl;
    logic      link_qual;
    logic      ev_enter, ev_exit, hw_clr_en;

    lpi_csr #(.ADDR_W(ADDR_W)) csr_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata),
        .hw_clr_en(hw_clr_en), .ev_enter(ev_enter), .ev_exit(ev_exit),
        .lpi_active(lpi_req),
        .ctrl(ctrl), .reg_rdata(reg_rdata)
    );

    lpi_link_qual #(.CNT_W(CNT_W)) lq_i (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .phy_link_up(phy_link_up), .ls_cycles(ls_cycles),
        .link_qual(link_qual)
    );

    lpi_tx_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst(rst), .ctrl(ctrl), .link_qual(link_qual),
        .frame_pending(frame_pending), .new_frame(new_frame),
        .fifo_flush(fifo_flush), .tw_cycles(tw_cycles),
        .lpi_req(lpi_req), .tx_ready(tx_ready),
        .ev_enter(ev_enter), .ev_exit(ev_exit), .hw_clr_en(hw_clr_en)
    );

    // R10
    active_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(CSR_OFFSET)) |-> reg_rdata[STS_ACTIVE] == lpi_req);

endmodule

// File: tb/eee_txlpi_ctrl_tb_top.sv
module eee_txlpi_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        frame_pending, new_frame, fifo_flush, phy_link_up;
    logic [15:0] ls_cycles, tw_cycles;
    logic        lpi_req, tx_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    eee_txlpi_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_pending(frame_pending), .new_frame(new_frame),
        .fifo_flush(fifo_flush), .phy_link_up(phy_link_up),
        .ls_cycles(ls_cycles), .tw_cycles(tw_cycles),
        .lpi_req(lpi_req), .tx_ready(tx_ready)
    );

    // addr, wdata, expected readback at 0x30
    localparam logic [71:0] VEC [6] = '{
        {8'h30, 32'h000F_FFFF, 32'h000F_0000},
        {8'h30, 32'hFFF0_FFFF, 32'h0000_0000},
        {8'h30, 32'h0005_0000, 32'h0005_0000},
        {8'h34, 32'h000F_0000, 32'h0005_0000},
        {8'h30, 32'h000A_0000, 32'h000A_0000},
        {8'h30, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h30;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 8'h30;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 8'h30; reg_wdata = 0;
        frame_pending = 0; new_frame = 0; fifo_flush = 0; phy_link_up = 0;
        step(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        ls_cycles = 16'd1000; tw_cycles = 16'd3;
        do_reset();

        // R11 reset state
        check("R11 lpi_req", {31'd0, lpi_req}, 32'd0);
        check("R11 tx_ready", {31'd0, tx_ready}, 32'd1);
        rd(8'h30, d); check("R11 reg", d, 32'd0);

        // R1 register vectors (long LS time keeps entry off)
        for (int v = 0; v < 6; v++) begin
            wr(VEC[v][71:64], VEC[v][63:32]);
            rd(8'h30, d);
            check("R1 readback", d, VEC[v][31:0]);
        end
        rd(8'h34, d); check("R1 other offset", d, 32'd0);

        // R2 R3 R10 manual entry timing, ls=4
        ls_cycles = 16'd4;
        do_reset();
        wr(8'h30, 32'h0003_0000);
        step(4);
        check("R2 before LS expiry", {31'd0, lpi_req}, 32'd0);
        // R9 collision: read during the entry edge keeps flag
        rd(8'h30, d);
        check("R3 entry", {31'd0, lpi_req}, 32'd1);
        rd(8'h30, d); check("R9 set wins + R10", d, 32'h0003_0101);
        rd(8'h30, d); check("R9 read clears", d, 32'h0003_0100);

        // R4 R5 manual exit, tw=3
        wr(8'h30, 32'h0002_0000);
        check("R4 still in LPI", {31'd0, lpi_req}, 32'd1);
        step(1);
        check("R4 exit", {30'd0, lpi_req, tx_ready}, 32'd0);
        step(2);
        check("R5 wake low", {31'd0, tx_ready}, 32'd0);
        step(1);
        check("R5 wake done", {31'd0, tx_ready}, 32'd1);
        rd(8'h30, d); check("R9 exit flag", d, 32'h0002_0002);

        // R2 PHY-qualified link
        do_reset();
        wr(8'h30, 32'h0007_0000);
        step(8);
        check("R2 phy down blocks", {31'd0, lpi_req}, 32'd0);
        phy_link_up = 1'b1;
        step(4);
        check("R2 phy before LS", {31'd0, lpi_req}, 32'd0);
        step(1);
        check("R2 phy entry", {31'd0, lpi_req}, 32'd1);

        // R6 R7 automatic mode
        ls_cycles = 16'd2;
        do_reset();
        frame_pending = 1'b1;
        wr(8'h30, 32'h000B_0000);
        step(8);
        check("R6 drain hold", {31'd0, lpi_req}, 32'd0);
        frame_pending = 1'b0;
        step(1);
        check("R6 entry after drain", {31'd0, lpi_req}, 32'd1);
        new_frame = 1'b1;
        step(1);
        new_frame = 1'b0;
        check("R7 new frame exit", {30'd0, lpi_req, tx_ready}, 32'd0);
        rd(8'h30, d); check("R7 enable cleared", d, 32'h000A_0001);
        step(2);
        rd(8'h30, d); check("R5 auto wake flag", d, 32'h000A_0002);
        check("R5 ready after wake", {31'd0, tx_ready}, 32'd1);
        wr(8'h30, 32'h000B_0000);
        step(1);
        check("R7 re-entry", {31'd0, lpi_req}, 32'd1);
        fifo_flush = 1'b1;
        step(1);
        fifo_flush = 1'b0;
        check("R7 flush exit", {31'd0, lpi_req}, 32'd0);
        rd(8'h30, d); check("R7 flush clears enable", d & 32'h000F_0000, 32'h000A_0000);

        // R8 manual flush
        do_reset();
        wr(8'h30, 32'h0003_0000);
        step(3);
        check("R8 in LPI", {31'd0, lpi_req}, 32'd1);
        fifo_flush = 1'b1;
        step(1);
        fifo_flush = 1'b0;
        check("R8 flush exit", {30'd0, lpi_req, tx_ready}, 32'd0);
        rd(8'h30, d); check("R8 enable kept", d & 32'h000F_0000, 32'h0003_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule